// File: doc/BRIEF.md
# Pattern-Triggered Word Boundary Aligner

This block sits behind a deserializer whose parallel words arrive with an unknown bit phase. Every clock it takes one W-bit word, joins it with the word from the previous clock into a 2W-bit window, and compares the pattern against every one of the W bit offsets in that window. The matching runs all the time. The block only acts on a match once an arming event has happened, which is a rising edge on `align_en`. The first match after that event fixes the word boundary. From then on the block emits words cut at the locked offset.

Two status outputs report what the block sees. `det_o` says that the word just emitted at the locked boundary equals the pattern. `sync_o` pulses in two cases: for one cycle when a boundary is locked, and afterwards whenever the pattern turns up at an offset other than the locked one. A pattern seen at another offset never moves the boundary. Only a fresh rising edge of `align_en` can change it, so the level of `align_en` does not matter once the block is locked. To move the boundary, the controller drops `align_en` and raises it again, and the search starts over.

Top module: `wba_top`

## Requirements
- R1: The search is armed only by a rising edge of `align_en`, which is found by comparing `align_en` with its value registered on the previous clock. A match counts in the very cycle of the edge. With no rising edge since reset, the block never locks, whatever it receives.
- R2: With P the previous word and C the current word, the window is {P, C} with P in the upper half. The candidate at offset k (0 to W-1) is window bits [k+W-1:k], so offset 0 is C itself. When several offsets match during a search, the lowest offset is locked, and `off_o` shows it as a binary offset number.
- R3: In the output cycle that follows the word completing the first match after arming, `locked_o`, `sync_o` and `det_o` are all 1 and `data_o` equals the pattern. Unless R6 applies, `sync_o` is 0 again in the next cycle.
- R4: While locked, each output cycle `data_o` is the candidate at the locked offset, built from the input words of the previous clock edge (one register of latency).
- R5: `det_o` is 1 exactly when the block is locked and the emitted `data_o` equals the pattern.
- R6: While locked with no search active, `sync_o` is 1 for each input window in which the pattern matches at an offset different from `off_o`, whatever the level of `align_en`. `off_o` stays unchanged.
- R7: A new rising edge of `align_en` re-arms the search. The old boundary stays in use until a match is found. The search stays armed across cycles with no match, even if `align_en` falls, and the next match sets the new offset. A falling edge by itself changes nothing.
- R8: Before the first lock, `data_o` is the current word (offset 0), and `sync_o`, `det_o`, `locked_o` and `off_o` are 0.
- R9: A synchronous active-high `rst` clears the lock, the stored offset, the arming state, the previous word and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | W | Unaligned parallel word |
| align_en | input | 1 | Arms the search on its rising edge |
| data_o | output | W | Realigned word |
| det_o | output | 1 | Pattern present at the locked boundary |
| sync_o | output | 1 | Lock pulse or off-boundary pattern pulse |
| locked_o | output | 1 | A boundary has been locked |
| off_o | output | $clog2(W) | Locked bit offset |

## Verification
The hardest cases to reach are an arming edge that finds no match, followed by a lock many cycles later after `align_en` has already fallen, and a window that matches at more than one offset in the same cycle. The bench forces the first case with a directed sequence: it raises `align_en` over filler words, drops it, then sends the pattern split across two words. The second case is covered by random runs that place the pattern at random offsets, sometimes in back-to-back windows, while `align_en` toggles at random. A bench model built from the requirements predicts every output in every cycle.

// File: rtl/wba_pkg.sv
package wba_pkg;

  // Per-cycle decision of the lock controller.
  typedef struct packed {
    logic lock_now;   // a search found a match in this window
    logic srch;       // a search is active in this window
    logic use_lock;   // the output word is cut at a locked offset
  } ctl_t;

endpackage

// File: rtl/wba_window.sv
module wba_window #(
  parameter int W = 8,
  parameter logic [W-1:0] PAT = 8'h3C
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   cur,
  output logic [W*W-1:0] cand_flat,
  output logic [W-1:0]   match
);

  localparam int DW = 2 * W;

  logic [W-1:0]  prev_q;
  logic [DW-1:0] dbl;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cur;
  end

  assign dbl = {prev_q, cur};

  for (genvar k = 0; k < W; k++) begin : g_off
    assign cand_flat[k*W +: W] = dbl[k +: W];
    assign match[k]            = (dbl[k +: W] == PAT);
  end

endmodule

// File: rtl/wba_prio.sv
module wba_prio #(
  parameter int W  = 8,
  parameter int OW = $clog2(W)
) (
  input  logic [W-1:0]  match,
  output logic          any,
  output logic [OW-1:0] first
);

  always_comb begin
    first = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (match[k]) first = OW'(k);
    end
  end

  assign any = |match;

endmodule

// File: rtl/wba_ctrl.sv
module wba_ctrl
  import wba_pkg::*;
#(
  parameter int W  = 8,
  parameter int OW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          align_en,
  input  logic [W-1:0]  match,
  input  logic          any,
  input  logic [OW-1:0] first,
  output ctl_t          ctl,
  output logic [OW-1:0] use_off,
  output logic          sync_d,
  output logic          locked_q,
  output logic [OW-1:0] off_q
);

  logic en_q;
  logic armed_q;
  logic rise;
  logic other_hit;

  assign rise         = align_en & ~en_q;
  assign ctl.srch     = armed_q | rise;
  assign ctl.lock_now = ctl.srch & any;
  assign ctl.use_lock = ctl.lock_now | locked_q;
  assign use_off      = ctl.lock_now ? first : off_q;

  always_comb begin
    other_hit = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (match[k] && (OW'(k) != off_q)) other_hit = 1'b1;
    end
  end

  assign sync_d = ctl.lock_now | (locked_q & ~ctl.srch & other_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
      off_q    <= '0;
    end else begin
      en_q <= align_en;
      if (ctl.lock_now) begin
        armed_q  <= 1'b0;
        locked_q <= 1'b1;
        off_q    <= first;
      end else begin
        armed_q  <= ctl.srch;
      end
    end
  end

endmodule

// File: rtl/wba_top.sv
module wba_top
  import wba_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] PAT = 8'h3C,
  localparam int OW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  in_word,
  input  logic          align_en,
  output logic [W-1:0]  data_o,
  output logic          det_o,
  output logic          sync_o,
  output logic          locked_o,
  output logic [OW-1:0] off_o
);

  logic [W*W-1:0] cand_flat;
  logic [W-1:0]   match;
  logic           any;
  logic [OW-1:0]  first;
  ctl_t           ctl;
  logic [OW-1:0]  use_off;
  logic           sync_d;

  wba_window #(.W(W), .PAT(PAT)) u_win (
    .clk(clk), .rst(rst), .cur(in_word),
    .cand_flat(cand_flat), .match(match)
  );

  wba_prio #(.W(W), .OW(OW)) u_prio (
    .match(match), .any(any), .first(first)
  );

  wba_ctrl #(.W(W), .OW(OW)) u_ctrl (
    .clk(clk), .rst(rst), .align_en(align_en),
    .match(match), .any(any), .first(first),
    .ctl(ctl), .use_off(use_off), .sync_d(sync_d),
    .locked_q(locked_o), .off_q(off_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      det_o  <= 1'b0;
      sync_o <= 1'b0;
    end else begin
      data_o <= cand_flat[use_off*W +: W];
      det_o  <= ctl.use_lock & match[use_off];
      sync_o <= sync_d;
    end
  end

endmodule

// File: rtl/wba_chk.sv
module wba_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] PAT = 8'h3C,
  parameter int OW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic          lock_now,
  input logic [W-1:0]  data_o,
  input logic          det_o,
  input logic          sync_o,
  input logic          locked_o,
  input logic [OW-1:0] off_o
);

  // R3: a match during a search shows up as lock, sync and detect together
  a_r3_lock_pulse: assert property (@(posedge clk) disable iff (rst)
    lock_now |=> (locked_o && sync_o && det_o));

  // R5: detect only for a locked boundary carrying the pattern
  a_r5_det_pattern: assert property (@(posedge clk) disable iff (rst)
    det_o |-> (locked_o && data_o == PAT));

  // R6: the locked offset moves only when a search finds a match
  a_r6_offset_hold: assert property (@(posedge clk) disable iff (rst)
    (locked_o && !lock_now) |=> $stable(off_o));

  // R8: nothing is reported before the first lock
  a_r8_prelock_quiet: assert property (@(posedge clk) disable iff (rst)
    !locked_o |-> (!sync_o && !det_o && off_o == '0));

  // R9: lock is never lost once taken, except by reset
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> locked_o);

endmodule

bind wba_top wba_chk #(.W(W), .PAT(PAT), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .lock_now(ctl.lock_now),
  .data_o(data_o), .det_o(det_o), .sync_o(sync_o),
  .locked_o(locked_o), .off_o(off_o)
);

// File: tb/sim_wba_top.sv
module sim_wba_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [W-1:0] PAT = 8'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] in_word = '0;
  logic align_en = 1'b0;
  logic [W-1:0] data_o;
  logic det_o, sync_o, locked_o;
  logic [2:0] off_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model state
  logic [W-1:0] m_prev;
  logic m_en, m_armed, m_locked;
  int   m_off;
  logic [W-1:0] e_data;
  logic e_det, e_sync, e_lockev;

  always #(CLK_PERIOD/2) clk = ~clk;

  wba_top #(.W(W), .PAT(PAT)) u0 (
    .clk(clk), .rst(rst), .in_word(in_word), .align_en(align_en),
    .data_o(data_o), .det_o(det_o), .sync_o(sync_o),
    .locked_o(locked_o), .off_o(off_o)
  );

  function automatic logic [W-1:0] f_cand(logic [W-1:0] p, logic [W-1:0] c, int k);
    logic [2*W-1:0] win;
    win = {p, c} >> k;
    return win[W-1:0];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_prev = '0; m_en = 0; m_armed = 0; m_locked = 0; m_off = 0;
  endtask

  task automatic model_step(logic [W-1:0] w, logic en);
    logic srch, hit, other;
    int fst;
    srch = m_armed | (en & ~m_en);
    hit = 0; other = 0; fst = 0;
    for (int k = W - 1; k >= 0; k--)
      if (f_cand(m_prev, w, k) == PAT) begin hit = 1; fst = k; end
    for (int k = 0; k < W; k++)
      if (f_cand(m_prev, w, k) == PAT && k != m_off) other = 1;
    e_lockev = srch && hit;
    if (e_lockev) begin
      m_locked = 1; m_off = fst; m_armed = 0; e_sync = 1;
    end else begin
      e_sync = m_locked && !srch && other;
      m_armed = srch;
    end
    e_data = f_cand(m_prev, w, m_off);
    e_det = m_locked && (e_data == PAT);
    m_en = en;
    m_prev = w;
  endtask

  task automatic cyc(logic [W-1:0] w, logic en);
    @(negedge clk);
    in_word = w; align_en = en;
    model_step(w, en);
    @(posedge clk); #1;
    if (m_locked) chk("R4", "data_o", data_o, e_data);
    else          chk("R8", "data_o", data_o, e_data);
    chk("R5", "det_o", det_o, e_det);
    if (e_lockev) chk("R3", "sync_o", sync_o, e_sync);
    else          chk("R6", "sync_o", sync_o, e_sync);
    chk("R7", "locked_o", locked_o, m_locked);
    chk("R7", "off_o", off_o, m_off);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd4711);
    model_reset();
    in_word = 8'hA5; align_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "data_o in reset", data_o, 0);
    chk("R9", "locked_o in reset", locked_o, 0);
    chk("R9", "sync_o in reset", sync_o, 0);
    @(negedge clk); rst = 1'b0; align_en = 1'b0;

    // R1: pattern with no rising edge never locks
    for (int i = 0; i < 4; i++) begin
      cyc(PAT, 1'b0);
      chk("R1", "locked without edge", locked_o, 0);
      chk("R8", "word at offset 0", data_o, PAT);
    end

    // R2: pattern split across words at offset 3, lock on the edge cycle
    cyc(8'h01, 1'b0);
    cyc(8'hE0, 1'b1);
    chk("R2", "offset 3", off_o, 3);
    chk("R3", "lock sync", sync_o, 1);
    chk("R3", "lock data", data_o, PAT);
    cyc(8'h00, 1'b1);
    chk("R3", "sync one cycle", sync_o, 0);

    // R6: pattern at offset 0 while locked at 3, enable high then low
    cyc(PAT, 1'b1);
    chk("R6", "resync pulse en high", sync_o, 1);
    cyc(PAT, 1'b0);
    chk("R6", "resync pulse en low", sync_o, 1);
    chk("R6", "offset held", off_o, 3);

    // R7: edge with no match, enable falls, later match relocks at 5
    cyc(8'h11, 1'b1);
    cyc(8'h22, 1'b0);
    cyc(8'h44, 1'b0);
    chk("R7", "old offset kept while armed", off_o, 3);
    cyc(8'h07, 1'b0);
    cyc(8'h80, 1'b0);
    chk("R7", "relock offset 5", off_o, 5);
    chk("R7", "relock sync", sync_o, 1);

    // random stream with injected patterns and toggling enable
    begin
      logic en = 0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom % 16 == 0) en = ~en;
        if ($urandom % 4 == 0) begin
          logic [2*W-1:0] inj;
          inj = {{W{1'b0}}, PAT} << ($urandom % W);
          cyc(inj[2*W-1:W] | W'($urandom % 2), en);
          cyc(inj[W-1:0], en);
        end else begin
          cyc(W'($urandom), en);
        end
      end
    end

    // R9: reset while locked clears everything
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R9", "locked_o after reset", locked_o, 0);
    chk("R9", "off_o after reset", off_o, 0);
    chk("R9", "det_o after reset", det_o, 0);
    @(negedge clk); rst = 1'b0; align_en = 1'b0;
    model_reset();
    cyc(8'h5A, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule